// File: doc/BRIEF.md
# Receive I/Q Channel Conditioner

This stage sits on the receive side, after the serial link deframer. Each 32-bit word it accepts holds one complex sample. The stage splits that word into an in-phase (I) stream and a quadrature (Q) stream.

Each stream has its own first-order high-pass filter, which removes the DC offset that the converter adds. After the filters, the pair goes through a gain and phase imbalance correction that rebuilds Q from a weighted sum of I and Q. Each of the two stages can be bypassed. The output latency is two cycles in every combination of modes, so downstream packing logic never has to track the mode.

Configuration lives in two registers that are loaded through a simple write strobe. The control register holds the two enables and the filter shift. The coefficient register holds the two correction weights. The two output samples leave with separate valid flags, ready for a later packing stage.

Top module: `rx_iq_cond`

## Requirements
- R1: Input bits [15:0] carry the I sample and bits [31:16] carry the Q sample, both two's complement. With every stage bypassed, `outI` and `outQ` equal those fields unchanged.
- R2: `outIValid` and `outQValid` are high exactly two clock edges after a word was presented with `inValid` high. While they are low, `outI` and `outQ` hold their previous values.
- R3: With the filter enabled, each stream produces y = x - (acc >>> 16) from a signed 32-bit accumulator acc. Each valid sample then updates the accumulator to acc + (((x << 16) - acc) >>> k), where k is the 4-bit shift (0 to 15) and both shifts round toward minus infinity.
- R4: The filter output saturates to the range -32768 to 32767.
- R5: The accumulator changes only on a valid sample while the filter is enabled. With the filter disabled, samples pass through it unchanged.
- R6: Every write to the control register clears both accumulators to zero. If a write and a valid sample arrive in the same cycle, the clear wins.
- R7: With correction enabled, I' = I and Q' = (c1*I + c2*Q) >>> 14, with c1 and c2 as signed values having 14 fractional bits. With correction disabled, Q' = Q.
- R8: The corrected Q' saturates to the range -32768 to 32767.
- R9: The latency from input to output is two cycles, whichever stages are enabled.
- R10: After reset, both outputs and both valids are zero and both stages are disabled. The coefficients reset to c1 = 0 and c2 = 16384 (1.0), so enabling correction without loading coefficients leaves Q unchanged.
- R11: When `cfgSel` is 0, a write loads the control register: bit 0 enables the filter, bit 1 enables correction, and bits [11:8] set k. When `cfgSel` is 1, a write loads the coefficient register: c1 from bits [15:0] and c2 from bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word is valid |
| inData | input | 32 | Packed Q/I input word |
| cfgWrite | input | 1 | Register write strobe |
| cfgSel | input | 1 | 0 selects the control register, 1 selects the coefficient register |
| cfgWdata | input | 32 | Register write data |
| outI | output | 16 | Conditioned I sample |
| outQ | output | 16 | Conditioned Q sample |
| outIValid | output | 1 | `outI` is valid |
| outQValid | output | 1 | `outQ` is valid |

## Verification
Some properties are checked by assertions on every cycle:
- the valid pipeline and its two-cycle latency;
- that outputs hold while no sample is valid;
- the passthrough of a disabled filter and of I through the correction stage;
- that the accumulator stays frozen unless it is updated or cleared, and that it reads zero after a clear;
- that the coefficients stay stable unless they are written.

The arithmetic needs the bench's scenarios:
- the decay of a constant input under different shifts;
- saturation at both full-scale ends;
- the weighted Q sum and its clipping;
- the effect of a control write in the middle of a stream.

A behavioural model compares both outputs and both valids on every clock.

// File: rtl/rx_iq_pkg.sv
package rx_iq_pkg;

  localparam int SAMPLE_W  = 16;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;
  localparam int SHIFT_W   = 4;
  localparam int ACC_W     = 32;
  localparam int CFG_W     = 32;

  typedef struct packed {
    logic                     dcEn;
    logic                     corrEn;
    logic [SHIFT_W-1:0]       dcShift;
    logic signed [COEF_W-1:0] coefA;
    logic signed [COEF_W-1:0] coefB;
  } cfg_t;

  typedef struct packed {
    logic dcClear;
  } strobe_t;

endpackage

// File: rtl/rx_iq_ctrl.sv
module rx_iq_ctrl
  import rx_iq_pkg::*;
#(
  parameter int DATA_W    = CFG_W,
  parameter int FRAC_BITS = COEF_FRAC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgWdata,
  output cfg_t              cfg,
  output strobe_t           strobe
);

  localparam int DC_BIT    = 0;
  localparam int CORR_BIT  = 1;
  localparam int SHIFT_LSB = 8;
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_BITS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg.dcEn    <= 1'b0;
      cfg.corrEn  <= 1'b0;
      cfg.dcShift <= '0;
      cfg.coefA   <= '0;
      cfg.coefB   <= UNITY;
    end else if (cfgWrite) begin
      if (!cfgSel) begin
        cfg.dcEn    <= cfgWdata[DC_BIT];
        cfg.corrEn  <= cfgWdata[CORR_BIT];
        cfg.dcShift <= cfgWdata[SHIFT_LSB +: SHIFT_W];
      end else begin
        cfg.coefA <= cfgWdata[0 +: COEF_W];
        cfg.coefB <= cfgWdata[COEF_W +: COEF_W];
      end
    end
  end

  always_comb begin
    strobe.dcClear = cfgWrite && !cfgSel;
  end

  // R11: coefficients change only on a coefficient-register write
  p_coef_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrite && cfgSel) |=> ($stable(cfg.coefA) && $stable(cfg.coefB)));

endmodule

// File: rtl/rx_iq_dcfilt.sv
module rx_iq_dcfilt #(
  parameter int SW      = 16,
  parameter int ACC_W   = 32,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [SW-1:0]      sampleIn,
  input  logic               enable,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               clear,
  output logic [SW-1:0]      sampleOut
);

  localparam int FRAC_W = ACC_W - SW;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W:0]   xScaled;
  logic signed [ACC_W:0]   accExt;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W:0]   step;
  logic signed [ACC_W:0]   accSum;
  logic signed [SW-1:0]    dcInt;
  logic signed [SW:0]      yWide;
  logic [SW-1:0]           ySat;

  always_comb begin
    xScaled = {sampleIn[SW-1], sampleIn, {FRAC_W{1'b0}}};
    accExt  = {acc[ACC_W-1], acc};
    diff    = xScaled - accExt;
    step    = diff >>> shift;
    accSum  = accExt + step;
    dcInt   = acc[ACC_W-1 -: SW];
    yWide   = {sampleIn[SW-1], sampleIn} - {dcInt[SW-1], dcInt};
    if (yWide[SW] != yWide[SW-1]) begin
      ySat = {yWide[SW], {(SW-1){~yWide[SW]}}};
    end else begin
      ySat = yWide[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      sampleOut <= '0;
    end else begin
      if (clear) begin
        acc <= '0;
      end else if (sampleValid && enable) begin
        acc <= accSum[ACC_W-1:0];
      end
      if (sampleValid) begin
        sampleOut <= enable ? ySat : sampleIn;
      end
    end
  end

  // R5: accumulator frozen unless a valid sample arrives while enabled
  p_dc_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !(sampleValid && enable)) |=> $stable(acc));

  // R6: a clear leaves the accumulator at zero
  p_dc_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (acc == '0));

  // R5: a disabled filter passes the sample unchanged
  p_dc_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !enable) |=> (sampleOut == $past(sampleIn)));

  // R2: the stage output holds without a valid sample
  p_dc_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(sampleOut));

endmodule

// File: rtl/rx_iq_datapath.sv
module rx_iq_datapath
  import rx_iq_pkg::*;
#(
  parameter int SW        = SAMPLE_W,
  parameter int AW        = ACC_W,
  parameter int CW        = COEF_W,
  parameter int FRAC_BITS = COEF_FRAC,
  parameter int KW        = SHIFT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2*SW-1:0]   inData,
  input  cfg_t              cfg,
  input  strobe_t           strobe,
  output logic [SW-1:0]     outI,
  output logic [SW-1:0]     outQ,
  output logic              outIValid,
  output logic              outQValid
);

  localparam int CHANNELS = 2;
  localparam int PROD_W   = SW + CW;
  localparam int SUM_W    = PROD_W + 1;
  localparam int HI_W     = SUM_W - SW + 1;

  logic [SW-1:0] stage1 [CHANNELS];
  logic          s1Valid;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_dc
    rx_iq_dcfilt #(
      .SW(SW),
      .ACC_W(AW),
      .SHIFT_W(KW)
    ) u_dc (
      .clk(clk),
      .rstN(rstN),
      .sampleValid(inValid),
      .sampleIn(inData[ch*SW +: SW]),
      .enable(cfg.dcEn),
      .shift(cfg.dcShift),
      .clear(strobe.dcClear),
      .sampleOut(stage1[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
    end else begin
      s1Valid <= inValid;
    end
  end

  logic signed [PROD_W-1:0] prodA;
  logic signed [PROD_W-1:0] prodB;
  logic signed [SUM_W-1:0]  sum;
  logic signed [SUM_W-1:0]  scaled;
  logic [HI_W-1:0]          hiBits;
  logic [SW-1:0]            qSat;

  always_comb begin
    prodA  = $signed(cfg.coefA) * $signed(stage1[0]);
    prodB  = $signed(cfg.coefB) * $signed(stage1[1]);
    sum    = {prodA[PROD_W-1], prodA} + {prodB[PROD_W-1], prodB};
    scaled = sum >>> FRAC_BITS;
    hiBits = scaled[SUM_W-1:SW-1];
    if ((&hiBits) || !(|hiBits)) begin
      qSat = scaled[SW-1:0];
    end else begin
      qSat = {scaled[SUM_W-1], {(SW-1){~scaled[SUM_W-1]}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outI      <= '0;
      outQ      <= '0;
      outIValid <= 1'b0;
      outQValid <= 1'b0;
    end else begin
      outIValid <= s1Valid;
      outQValid <= s1Valid;
      if (s1Valid) begin
        outI <= stage1[0];
        outQ <= cfg.corrEn ? qSat : stage1[1];
      end
    end
  end

  // R2: accepted word moves into the first stage
  p_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> s1Valid);

  // R9: first stage always reaches the outputs one edge later
  p_lat_r9: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> (outIValid && outQValid));

  // R2: no spurious output valid
  p_novalid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !s1Valid |=> (!outIValid && !outQValid));

  // R7: I passes the correction stage unchanged
  p_ipass_r7: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> (outI == $past(stage1[0])));

  // R7: correction bypass keeps Q
  p_corr_bypass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !cfg.corrEn) |=> (outQ == $past(stage1[1])));

  // R2: outputs hold without a valid sample
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !s1Valid |=> ($stable(outI) && $stable(outQ)));

endmodule

// File: rtl/rx_iq_cond.sv
module rx_iq_cond
  import rx_iq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [2*SAMPLE_W-1:0] inData,
  input  logic                cfgWrite,
  input  logic                cfgSel,
  input  logic [CFG_W-1:0]    cfgWdata,
  output logic [SAMPLE_W-1:0] outI,
  output logic [SAMPLE_W-1:0] outQ,
  output logic                outIValid,
  output logic                outQValid
);

  cfg_t    cfg;
  strobe_t strobe;

  rx_iq_ctrl #(
    .DATA_W(CFG_W),
    .FRAC_BITS(COEF_FRAC)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .cfgWrite(cfgWrite),
    .cfgSel(cfgSel),
    .cfgWdata(cfgWdata),
    .cfg(cfg),
    .strobe(strobe)
  );

  rx_iq_datapath #(
    .SW(SAMPLE_W),
    .AW(ACC_W),
    .CW(COEF_W),
    .FRAC_BITS(COEF_FRAC),
    .KW(SHIFT_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .inValid(inValid),
    .inData(inData),
    .cfg(cfg),
    .strobe(strobe),
    .outI(outI),
    .outQ(outQ),
    .outIValid(outIValid),
    .outQValid(outQValid)
  );

endmodule

// File: tb/rx_iq_cond_test.sv
module rx_iq_cond_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        cfgWrite = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [15:0] outI;
  logic [15:0] outQ;
  logic        outIValid;
  logic        outQValid;

  int    checks = 0;
  int    errors = 0;
  string tag = "R10";

  always #(CLK_P/2) clk = ~clk;

  rx_iq_cond uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .outI(outI), .outQ(outQ), .outIValid(outIValid), .outQValid(outQValid)
  );

  // behavioural reference
  int     mDcEn, mCorrEn, mShift;
  longint mA, mB;
  longint accM [2];
  int     p1v, p1i, p1q;
  int     expV, expI, expQ;

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDcEn = 0; mCorrEn = 0; mShift = 0; mA = 0; mB = 16384;
      accM[0] = 0; accM[1] = 0;
      p1v = 0; p1i = 0; p1q = 0; expV = 0; expI = 0; expQ = 0;
    end else begin
      expV = p1v;
      if (p1v != 0) begin
        expI = p1i;
        expQ = (mCorrEn != 0) ? sat16((mA * p1i + mB * p1q) >>> 14) : p1q;
      end
      p1v = int'(inValid);
      if (inValid) begin
        for (int ch = 0; ch < 2; ch++) begin
          int x;
          int y;
          x = (ch == 0) ? int'($signed(inData[15:0])) : int'($signed(inData[31:16]));
          if (mDcEn != 0) begin
            y = sat16(longint'(x) - (accM[ch] >>> 16));
            accM[ch] = accM[ch] + (((longint'(x) * 65536) - accM[ch]) >>> mShift);
          end else begin
            y = x;
          end
          if (ch == 0) p1i = y; else p1q = y;
        end
      end
      if (cfgWrite) begin
        if (!cfgSel) begin
          mDcEn = int'(cfgWdata[0]);
          mCorrEn = int'(cfgWdata[1]);
          mShift = int'(cfgWdata[11:8]);
          accM[0] = 0; accM[1] = 0;
        end else begin
          mA = longint'($signed(cfgWdata[15:0]));
          mB = longint'($signed(cfgWdata[31:16]));
        end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (!rstN) begin
      if (outI !== 16'd0 || outQ !== 16'd0 || outIValid !== 1'b0 || outQValid !== 1'b0) begin
        errors++;
        $display("FAIL R10 reset outputs act I=%h Q=%h v=%b%b exp 0000 0000 00",
                 outI, outQ, outIValid, outQValid);
      end
    end else begin
      if (outIValid !== expV[0] || outQValid !== expV[0]) begin
        errors++;
        $display("FAIL %s valid act %b%b exp %0d", tag, outIValid, outQValid, expV);
      end
      if (int'($signed(outI)) != expI || int'($signed(outQ)) != expQ) begin
        errors++;
        $display("FAIL %s data act I=%0d Q=%0d exp I=%0d Q=%0d", tag,
                 $signed(outI), $signed(outQ), expI, expQ);
      end
    end
  end

  task automatic sendWord(input logic v, input logic [31:0] d);
    @(negedge clk);
    inValid = v;
    inData = d;
  endtask

  task automatic sendIQ(input int i, input int q);
    sendWord(1'b1, {q[15:0], i[15:0]});
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) sendWord(1'b0, inData);
  endtask

  task automatic cfgWr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    inValid = 1'b0;
    cfgWrite = 1'b1;
    cfgSel = sel;
    cfgWdata = d;
    @(negedge clk);
    cfgWrite = 1'b0;
    idle(3);
  endtask

  task automatic randomStream(input int n, input bit gaps);
    for (int c = 0; c < n; c++) begin
      logic v;
      v = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
      sendWord(v, $urandom());
    end
    idle(3);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog act timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R10";
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    tag = "R1 R2 R9";
    randomStream(40, 1'b1);
    sendIQ(-1, 12345);
    sendIQ(-32768, 32767);
    idle(3);

    tag = "R10";
    cfgWr(1'b0, 32'h0000_0002);
    randomStream(12, 1'b0);

    tag = "R7 R11";
    cfgWr(1'b1, 32'h3000_1000);
    randomStream(30, 1'b1);
    cfgWr(1'b1, 32'hE000_C000);
    randomStream(20, 1'b0);

    tag = "R8";
    cfgWr(1'b1, 32'h4000_4000);
    sendIQ(30000, 30000);
    sendIQ(-30000, -30000);
    sendIQ(32767, -32768);
    randomStream(20, 1'b0);

    tag = "R3";
    cfgWr(1'b0, 32'h0000_0401);
    for (int c = 0; c < 60; c++) sendIQ(1000, -700);
    idle(3);
    cfgWr(1'b0, 32'h0000_0001);
    sendIQ(500, -500);
    sendIQ(800, 300);
    sendIQ(-200, 100);
    idle(3);
    cfgWr(1'b0, 32'h0000_0F01);
    for (int c = 0; c < 40; c++) sendIQ(20000, -20000);
    idle(3);

    tag = "R4";
    cfgWr(1'b0, 32'h0000_0001);
    sendIQ(-32768, 32767);
    sendIQ(32767, -32768);
    sendIQ(-32768, 32767);
    idle(3);

    tag = "R5";
    cfgWr(1'b0, 32'h0000_0301);
    randomStream(40, 1'b1);
    cfgWr(1'b0, 32'h0000_0300);
    randomStream(15, 1'b0);

    tag = "R6";
    cfgWr(1'b0, 32'h0000_0401);
    for (int c = 0; c < 20; c++) sendIQ(5000, -3000);
    idle(2);
    cfgWr(1'b0, 32'h0000_0401);
    sendIQ(5000, -3000);
    sendIQ(5000, -3000);
    @(negedge clk);
    inValid = 1'b1;
    inData = {16'd900, 16'd700};
    cfgWrite = 1'b1;
    cfgSel = 1'b0;
    cfgWdata = 32'h0000_0201;
    @(negedge clk);
    cfgWrite = 1'b0;
    inData = {16'd900, 16'd700};
    idle(4);

    tag = "R9";
    cfgWr(1'b1, 32'h3800_F400);
    cfgWr(1'b0, 32'h0000_0503);
    randomStream(60, 1'b1);

    idle(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule